// File: doc/BRIEF.md
# Serial-Bus Memory Target Front End

This block is the two-wire serial-bus target for a small byte-addressed non-volatile memory of 2048 bytes. Both bus lines are brought into a fast system clock through synchronisers. Start and stop conditions are found by comparing successive samples of the lines. The block shifts in the device-select byte, the word address and the data bytes, and acknowledges each byte by pulling SDA low. It drives SDA only through an active-high pull-down enable and never drives it high.

On the memory side the block offers two things. The first is a one-cycle byte-write request carrying an address and a data byte. The second is a read address, for which the back end must present the data byte combinationally. An internal address counter moves forward after every byte that is written or sent, so page writes and sequential reads need no extra address bytes. A busy input from the write sequencer stops the block from acknowledging its device address. A host can therefore poll until a self-timed write has finished.

Top module: `i2c_mem_target`

## Requirements
- R1: After reset, `sda_oe` and `wr_req` are low and the block waits for a start condition.
- R2: A byte after a start whose upper four bits are 1010 is the device-select byte. Bits 3:1 of that byte give address bits 10:8, and bit 0 gives the direction (1 = read, 0 = write). When `busy` is low, the block acknowledges this byte by holding `sda_oe` high through the ninth SCL clock.
- R3: If the upper four bits of the device-select byte are anything other than 1010, no acknowledge is given and SDA stays released until the next start or stop.
- R4: In a write transfer, the block acknowledges the word-address byte (address bits 7:0) and every data byte. Each acknowledged data byte gives exactly one single-cycle `wr_req`, with `wr_addr` and `wr_data` valid in that cycle.
- R5: The address counter steps forward by one after every data byte written or sent, and wraps from 0x7FF to 0x000.
- R6: A random read is a write of the device-select byte and the word address, then a repeated start and a read. It returns data MSB first, beginning at the addressed byte.
- R7: During a read, a low (acknowledge) from the host in the ninth clock makes the block send the next byte. A high (no acknowledge) makes it release SDA and keep it released until a start or stop.
- R8: While `busy` is high, the device-select byte gets no acknowledge. It is acknowledged again once `busy` is low.
- R9: A start or stop that arrives partway through a byte abandons that byte. It produces no `wr_req`, and a stop leaves SDA released.
- R10: `sda_oe` changes only while SCL is low, except when a start or stop forces it off.
- R11: A read with no new word address (current-address read) starts at the counter value left by the previous transfer. Its address bits 10:8 come from the device-select byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Sampled level of the SCL line |
| sda_in | input | 1 | Sampled level of the SDA line |
| sda_oe | output | 1 | When high, pull SDA low |
| busy | input | 1 | Write sequencer busy; suppresses the device-select acknowledge |
| wr_req | output | 1 | Single-cycle byte-write request |
| wr_addr | output | 11 | Address for `wr_req` |
| wr_data | output | 8 | Data byte for `wr_req` |
| rd_addr | output | 11 | Current counter address for the read path |
| rd_data | input | 8 | Byte at `rd_addr`, supplied combinationally by the back end |

## Verification
Two events can collide in this block. One is a start or stop condition. The other is the completion of a byte, which would otherwise issue a write request or an acknowledge. The bench provokes this with a stop after only four data bits, and with a repeated start placed right after an address acknowledge. It judges the result by the scoreboard, which must receive no unexpected write, and by whether the next transaction is acknowledged and returns the right data. Checks that `sda_oe` changes only while SCL is low confirm that the forced release on a start or stop never meets a normal bit change.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_WADDR,
      ST_WDATA,
      ST_ACK,
      ST_RDATA,
      ST_RACK,
      ST_WAIT
   } state_t;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_p, sda_p;
   logic scl_q, sda_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_p <= '1;
               sda_p <= '1;
            end else begin
               scl_p <= scl_in;
               sda_p <= sda_in;
            end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_p <= '1;
               sda_p <= '1;
            end else begin
               scl_p <= {scl_p[STAGES-2:0], scl_in};
               sda_p <= {sda_p[STAGES-2:0], sda_in};
            end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end

   assign scl_s     = scl_p[STAGES-1];
   assign sda_s     = sda_p[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cm_addr_ctr.sv
module i2cm_addr_ctr #(
   parameter int ADDR_W = 11,
   localparam int HI_W  = ADDR_W - 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_hi,
   input  logic [HI_W-1:0]   hi_val,
   input  logic              ld_lo,
   input  logic [7:0]        lo_val,
   input  logic              inc,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)
         addr <= '0;
      else if (inc)
         addr <= addr + ONE;
      else begin
         if (ld_hi) addr[ADDR_W-1:8] <= hi_val;
         if (ld_lo) addr[7:0]        <= lo_val;
      end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
   import i2cm_pkg::*;
#(
   parameter int           ADDR_W   = 11,
   parameter logic [3:0]   DEV_CODE = 4'b1010,
   localparam int          HI_W     = ADDR_W - 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic              busy,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        rd_data,
   output logic              ld_hi,
   output logic [HI_W-1:0]   hi_val,
   output logic              ld_lo,
   output logic [7:0]        lo_val,
   output logic              inc,
   output logic              sda_oe,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output state_t            st
);
   state_t     nxt;
   logic [7:0] shreg;
   logic [3:0] bitcnt;
   logic       quiet, rx_done, hit;

   assign quiet   = ~start_det & ~stop_det;
   assign rx_done = quiet & scl_fall & (bitcnt == 4'd8);
   assign hit     = (shreg[7:4] == DEV_CODE) & ~busy;
   assign hi_val  = shreg[HI_W:1];
   assign lo_val  = shreg;
   assign ld_hi   = rx_done & (st == ST_DEV) & hit;
   assign ld_lo   = rx_done & (st == ST_WADDR);
   assign inc     = (rx_done & (st == ST_WDATA)) |
                    (quiet & scl_fall & (st == ST_RDATA) & (bitcnt == 4'd7));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         st      <= ST_IDLE;
         nxt     <= ST_IDLE;
         shreg   <= '0;
         bitcnt  <= '0;
         sda_oe  <= 1'b0;
         wr_req  <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else begin
         wr_req <= 1'b0;
         if (start_det) begin
            st     <= ST_DEV;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               ST_DEV, ST_WADDR, ST_WDATA: begin
                  if (scl_rise && bitcnt != 4'd8) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (rx_done) begin
                     bitcnt <= '0;
                     if (st == ST_DEV) begin
                        if (hit) begin
                           sda_oe <= 1'b1;
                           st     <= ST_ACK;
                           nxt    <= shreg[0] ? ST_RDATA : ST_WADDR;
                        end else
                           st <= ST_WAIT;
                     end else begin
                        sda_oe <= 1'b1;
                        st     <= ST_ACK;
                        nxt    <= ST_WDATA;
                        if (st == ST_WDATA) begin
                           wr_req  <= 1'b1;
                           wr_data <= shreg;
                           wr_addr <= addr;
                        end
                     end
                  end
               end
               ST_ACK: if (scl_fall) begin
                  st     <= nxt;
                  bitcnt <= '0;
                  shreg  <= rd_data;
                  sda_oe <= (nxt == ST_RDATA) ? ~rd_data[7] : 1'b0;
               end
               ST_RDATA: if (scl_fall) begin
                  if (bitcnt == 4'd7) begin
                     sda_oe <= 1'b0;
                     st     <= ST_RACK;
                  end else begin
                     shreg  <= {shreg[6:0], 1'b0};
                     sda_oe <= ~shreg[6];
                     bitcnt <= bitcnt + 4'd1;
                  end
               end
               ST_RACK: begin
                  if (scl_rise && sda_s)
                     st <= ST_WAIT;
                  else if (scl_fall) begin
                     shreg  <= rd_data;
                     sda_oe <= ~rd_data[7];
                     bitcnt <= '0;
                     st     <= ST_RDATA;
                  end
               end
               default: ;
            endcase
         end
      end
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
   import i2cm_pkg::*;
#(
   parameter int         ADDR_W      = 11,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] DEV_CODE    = 4'b1010
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic              busy,
   output logic              wr_req,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [7:0]        rd_data
);
   localparam int HI_W = ADDR_W - 8;

   generate
      if (ADDR_W < 9 || ADDR_W > 11) begin : g_bad_addr
         $error("ADDR_W must lie in 9..11");
      end
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 1..4");
      end
   endgenerate

   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic ld_hi, ld_lo, inc;
   logic [HI_W-1:0]   hi_val;
   logic [7:0]        lo_val;
   logic [ADDR_W-1:0] addr;
   state_t            st;

   i2cm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   i2cm_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .hi_val(hi_val),
      .ld_lo(ld_lo), .lo_val(lo_val), .inc(inc), .addr(addr)
   );

   i2cm_engine #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .busy(busy), .addr(addr), .rd_data(rd_data), .ld_hi(ld_hi),
      .hi_val(hi_val), .ld_lo(ld_lo), .lo_val(lo_val), .inc(inc),
      .sda_oe(sda_oe), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .st(st)
   );

   assign rd_addr = addr;
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
   import i2cm_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   busy,
   input logic   sda_oe,
   input logic   wr_req,
   input logic   scl_s,
   input logic   start_det,
   input logic   stop_det,
   input state_t st
);
   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |=> !wr_req);

   a_r4_req_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> sda_oe);

   a_r8_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEV && busy) |=> !sda_oe);

   a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && st == ST_IDLE));

   a_r10_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);
endmodule

bind i2c_mem_target i2c_mem_target_chk u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .sda_oe(sda_oe), .wr_req(wr_req),
   .scl_s(scl_s), .start_det(start_det), .stop_det(stop_det), .st(st)
);

// File: tb/i2c_mem_target_test.sv
`timescale 1ns/1ps
module i2c_mem_target_test;
   localparam int Q = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_scl = 1'b1, host_sda = 1'b1, busy = 1'b0;
   logic sda_oe, wr_req, sda_line;
   logic [10:0] wr_addr, rd_addr;
   logic [7:0]  wr_data, rd_data;

   logic [7:0]  mem [2048];
   logic [7:0]  ref_mem [2048];
   logic [18:0] exp_q [$];
   int checks = 0, errors = 0;
   int oe_hits = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   assign sda_line = host_sda & ~sda_oe;
   assign rd_data  = mem[rd_addr];

   i2c_mem_target uut (
      .clk(clk), .rst_n(rst_n), .scl_in(host_scl), .sda_in(sda_line),
      .sda_oe(sda_oe), .busy(busy), .wr_req(wr_req), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor for write requests (R4, R5)
   logic prev_oe = 1'b0;
   always @(negedge clk) begin
      if (rst_n && wr_req) begin
         if (exp_q.size() == 0)
            check(0, "R9 unexpected wr_req", {wr_addr, wr_data}, 0);
         else begin
            logic [18:0] e;
            e = exp_q.pop_front();
            check({wr_addr, wr_data} == e, "R4/R5 write request", {wr_addr, wr_data}, e);
         end
         mem[wr_addr] <= wr_data;
      end
      if (rst_n && sda_oe !== prev_oe && host_scl)
         check(0, "R10 sda_oe changed with SCL high", sda_oe, prev_oe);
      if (sda_oe) oe_hits++;
      prev_oe = sda_oe;
   end

   task automatic wq(); repeat (Q) @(negedge clk); endtask

   task automatic bus_start();
      host_sda = 1'b1; wq(); host_scl = 1'b1; wq();
      host_sda = 1'b0; wq(); host_scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      host_sda = 1'b0; wq(); host_scl = 1'b1; wq();
      host_sda = 1'b1; wq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         host_sda = b[i]; wq(); host_scl = 1'b1; wq(); wq(); host_scl = 1'b0; wq();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      send_bits(b, 8);
      host_sda = 1'b1; wq(); host_scl = 1'b1; wq();
      ack = (sda_line == 1'b0);
      wq(); host_scl = 1'b0; wq();
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      host_sda = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); host_scl = 1'b1; wq(); b[i] = sda_line; wq(); host_scl = 1'b0;
      end
      wq(); host_sda = ~give_ack; wq(); host_scl = 1'b1; wq(); wq();
      host_scl = 1'b0; wq(); host_sda = 1'b1;
   endtask

   task automatic push_write(input logic [10:0] a, input logic [7:0] d);
      exp_q.push_back({a, d});
      ref_mem[a] = d;
   endtask

   task automatic drain();
      repeat (4 * Q) @(negedge clk);
      check(exp_q.size() == 0, "R4 all writes seen", exp_q.size(), 0);
   endtask

   function automatic logic [7:0] dsel(input logic [10:0] a, input bit rd);
      return {4'b1010, a[10:8], rd};
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      bit ack;
      logic [7:0] b;
      logic [10:0] a;
      for (int i = 0; i < 2048; i++) begin
         mem[i] = 8'(i * 7 + 3);
         ref_mem[i] = 8'(i * 7 + 3);
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
      check(wr_req == 1'b0, "R1 wr_req after reset", wr_req, 0);

      // R2, R4, R5: page write of three bytes at 0x5A3
      a = 11'h5A3;
      bus_start();
      send_byte(dsel(a, 0), ack); check(ack, "R2 device select ack", ack, 1);
      send_byte(a[7:0], ack);     check(ack, "R4 word address ack", ack, 1);
      for (int k = 0; k < 3; k++) begin
         push_write(a + 11'(k), 8'hC0 + 8'(k));
         send_byte(8'hC0 + 8'(k), ack); check(ack, "R4 data ack", ack, 1);
      end
      bus_stop();
      drain();

      // R6, R7: random read of four bytes, last one not acknowledged
      bus_start();
      send_byte(dsel(a, 0), ack);
      send_byte(a[7:0], ack); check(ack, "R6 dummy write address ack", ack, 1);
      bus_start();
      send_byte(dsel(a, 1), ack); check(ack, "R6 read select ack", ack, 1);
      for (int k = 0; k < 4; k++) begin
         recv_byte(k != 3, b);
         check(b == ref_mem[a + 11'(k)], "R6/R7 sequential read data", b, ref_mem[a + 11'(k)]);
      end
      // R7: after the no-ack, another byte clocked must see a released line
      oe_hits = 0;
      recv_byte(0, b);
      check(b == 8'hFF && oe_hits == 0, "R7 released after no-ack", b, 8'hFF);
      bus_stop();

      // R11: current-address read continues at 0x5A7
      bus_start();
      send_byte(dsel(a, 1), ack); check(ack, "R11 current read ack", ack, 1);
      recv_byte(0, b);
      check(b == ref_mem[11'h5A7], "R11 current address data", b, ref_mem[11'h5A7]);
      bus_stop();

      // R3: wrong device code
      bus_start();
      send_byte(8'b1011_0000, ack); check(!ack, "R3 foreign code not acked", ack, 0);
      oe_hits = 0;
      send_byte(8'h12, ack);
      check(!ack && oe_hits == 0, "R3 ignored until start", oe_hits, 0);
      bus_stop();

      // R8: busy suppresses the device-select ack
      busy = 1'b1;
      bus_start();
      send_byte(dsel(a, 0), ack); check(!ack, "R8 no ack while busy", ack, 0);
      bus_stop();
      busy = 1'b0;
      bus_start();
      send_byte(dsel(a, 0), ack); check(ack, "R8 ack after busy clears", ack, 1);
      bus_stop();

      // R9: stop after four data bits abandons the byte
      a = 11'h123;
      bus_start();
      send_byte(dsel(a, 0), ack);
      send_byte(a[7:0], ack);
      send_bits(8'hA5, 4);
      host_scl = 1'b1; wq();
      host_sda = 1'b0; wq(); host_sda = 1'b1; wq(); // stop: SDA low->high with SCL high
      check(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
      drain();
      // next transaction after the abort still works
      bus_start();
      send_byte(dsel(a, 0), ack); check(ack, "R9 recovery ack", ack, 1);
      send_byte(a[7:0], ack);
      push_write(a, 8'h3C);
      send_byte(8'h3C, ack);
      bus_stop();
      drain();

      // R5: wrap from 0x7FF to 0x000
      a = 11'h7FF;
      bus_start();
      send_byte(dsel(a, 0), ack);
      send_byte(a[7:0], ack);
      push_write(11'h7FF, 8'h81);
      send_byte(8'h81, ack);
      push_write(11'h000, 8'h82);
      send_byte(8'h82, ack); check(ack, "R5 wrapped byte ack", ack, 1);
      bus_stop();
      drain();
      bus_start();
      send_byte(dsel(11'h000, 0), ack);
      send_byte(8'h00, ack);
      bus_start();
      send_byte(dsel(11'h000, 1), ack);
      recv_byte(0, b);
      check(b == 8'h82, "R5 wrapped data read back", b, 8'h82);
      bus_stop();
      drain();

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule